// File: doc/BRIEF.md
# Parallel-Jam Serial-Out Shift Register

This block is a chain of storage stages with two ways of filling it. With the mode input low, the chain acts as an ordinary shift register. On every rising clock edge a new bit enters from the serial input at the first stage, and every other stage takes the value its upstream neighbour held before the edge. With the mode input high, each stage is forced to its own parallel data bit at once. This forcing does not wait for a clock edge, and it keeps tracking the parallel bits for as long as the mode input stays high.

Only the last few stages are visible, and the final stage is the serial output. The block serves as a parallel-to-serial converter. A caller raises the mode input to capture a word, lowers it again, and then clocks the word out one bit per rising edge, last stage first. The block has no reset. Its contents are unknown until the first parallel capture, or until a full register length of serial bits has been shifted in.

Top module: `jam_shift_reg`

## Requirements
- R1: The register holds STAGES stages (default 8). Stage i (1-based) has its own parallel input bit par_in[i-1]. A bit captured into stage 1 reaches the last stage after STAGES-1 shifts.
- R2: While load_en is 0, each rising edge of clk moves ser_in into stage 1, and stage n takes the value stage n-1 held before the edge.
- R3: While load_en is 1, every stage equals its parallel input bit, with no clock edge needed. A 0 bit gives 0 and a 1 bit gives 1.
- R4: While load_en is 1, clock edges and ser_in have no effect on any stage.
- R5: A change of a parallel input bit while load_en is 1 reaches the matching stage immediately.
- R6: taps[j] is stage TAP_FIRST+j, with TAP_FIRST defaulting to 6. With the defaults, taps[0] is stage 6, taps[1] is stage 7 and taps[2] is stage 8, the last stage. No other stage is visible.
- R7: While load_en is 0, a falling clock edge or a steady clock leaves every stage unchanged.
- R8: When load_en goes from 1 to 0, the captured values stay in place. Later changes of par_in have no effect, and shifting resumes at the next rising clk edge.
- R9: After STAGES consecutive serial shifts, the contents depend only on the serial bits: stage n holds the bit shifted in n-1 edges earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock. Only rising edges act. |
| load_en | input | 1 | Mode. 1 forces parallel capture, level-sensitive. 0 selects serial shifting. |
| par_in | input | STAGES | Parallel data. Bit i-1 feeds stage i. |
| ser_in | input | 1 | Serial data into stage 1. |
| taps | output | STAGES-TAP_FIRST+1 | Stages TAP_FIRST through STAGES. The top bit is the last stage. |

## Verification
The parallel capture and the clocked shift can fall on the same instant: a rising clock edge can arrive while load_en is held high. The bench provokes this by pulsing the clock during capture, with the serial input set opposite to the captured bits. It judges the result by requiring the taps to still equal the parallel bits afterwards. The bench also changes parallel bits and pulses load_en between clock edges. It checks that the next shift starts from the captured word and not from the pre-capture contents.

// File: rtl/jam_shift_pkg.sv
package jam_shift_pkg;

   // Per-stage force request, derived from the mode level and the data bit.
   typedef struct packed {
      logic force_one;
      logic force_zero;
   } jam_req_t;

   // Build the force request for one stage.
   function automatic jam_req_t make_req(input logic mode, input logic bit_in);
      jam_req_t r;
      r.force_one  = mode & bit_in;
      r.force_zero = mode & ~bit_in;
      return r;
   endfunction

endpackage

// File: rtl/jam_req_gen.sv
module jam_req_gen
   import jam_shift_pkg::*;
#(
   parameter int STAGES = 8
) (
   input  logic              load_en,
   input  logic [STAGES-1:0] par_in,
   output logic [STAGES-1:0] set_vec,
   output logic [STAGES-1:0] clr_vec
);

   for (genvar i = 0; i < STAGES; i++) begin : g_req
      jam_req_t req;
      always_comb begin
         req        = make_req(load_en, par_in[i]);
         set_vec[i] = req.force_one;
         clr_vec[i] = req.force_zero;
      end
   end

endmodule

// File: rtl/jam_stage.sv
module jam_stage (
   input  logic clk,
   input  logic force_one,
   input  logic force_zero,
   input  logic d,
   output logic q
);

   // Force inputs act as asynchronous preset/clear; while either is held,
   // clock edges cannot move the stored bit.
   always_ff @(posedge clk or posedge force_one or posedge force_zero) begin
      if (force_zero)     q <= 1'b0;
      else if (force_one) q <= 1'b1;
      else                q <= d;
   end

endmodule

// File: rtl/jam_chain.sv
module jam_chain #(
   parameter int STAGES = 8
) (
   input  logic              clk,
   input  logic              ser_in,
   input  logic [STAGES-1:0] set_vec,
   input  logic [STAGES-1:0] clr_vec,
   output logic [STAGES-1:0] state
);

   logic [STAGES-1:0] next_d;

   assign next_d = {state[STAGES-2:0], ser_in};

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      jam_stage u_stage (
         .clk       (clk),
         .force_one (set_vec[i]),
         .force_zero(clr_vec[i]),
         .d         (next_d[i]),
         .q         (state[i])
      );
   end

endmodule

// File: rtl/jam_shift_reg.sv
module jam_shift_reg #(
   parameter  int STAGES    = 8,
   parameter  int TAP_FIRST = 6,
   localparam int TAP_COUNT = STAGES - TAP_FIRST + 1
) (
   input  logic                 clk,
   input  logic                 load_en,
   input  logic [STAGES-1:0]    par_in,
   input  logic                 ser_in,
   output logic [TAP_COUNT-1:0] taps
);

   localparam int TAP_LSB = TAP_FIRST - 1;

   if (STAGES < 2) begin : g_bad_len
      $error("jam_shift_reg: STAGES must be at least 2");
   end
   if (TAP_FIRST < 1 || TAP_FIRST > STAGES) begin : g_bad_tap
      $error("jam_shift_reg: TAP_FIRST must lie in 1..STAGES");
   end

   logic [STAGES-1:0] set_vec;
   logic [STAGES-1:0] clr_vec;
   logic [STAGES-1:0] state;

   jam_req_gen #(.STAGES(STAGES)) u_req (
      .load_en(load_en),
      .par_in (par_in),
      .set_vec(set_vec),
      .clr_vec(clr_vec)
   );

   jam_chain #(.STAGES(STAGES)) u_chain (
      .clk    (clk),
      .ser_in (ser_in),
      .set_vec(set_vec),
      .clr_vec(clr_vec),
      .state  (state)
   );

   assign taps = state[STAGES-1:TAP_LSB];

endmodule

// File: rtl/jam_shift_reg_chk.sv
module jam_shift_reg_chk #(
   parameter  int STAGES    = 8,
   parameter  int TAP_FIRST = 6,
   localparam int TAP_COUNT = STAGES - TAP_FIRST + 1
) (
   input logic                 clk,
   input logic                 load_en,
   input logic [STAGES-1:0]    par_in,
   input logic                 ser_in,
   input logic [TAP_COUNT-1:0] taps
);

   localparam int TAP_LSB = TAP_FIRST - 1;

   // Contents are unknown until the first capture; checks wait for it.
   logic primed   = 1'b0;
   // Set when a capture occurred since the previous rising clock edge.
   logic jam_seen = 1'b0;

   always_ff @(posedge load_en) primed <= 1'b1;

   always_ff @(posedge clk or posedge load_en) begin
      if (load_en) jam_seen <= 1'b1;
      else         jam_seen <= 1'b0;
   end

   // R3
   jam_level_chk: assert property (@(negedge clk) disable iff (!primed)
      load_en |-> taps == par_in[STAGES-1:TAP_LSB]);

   // R4
   jam_over_clock_chk: assert property (@(posedge clk) disable iff (!primed)
      load_en |-> taps == par_in[STAGES-1:TAP_LSB]);

   // R4
   jam_hold_chk: assert property (@(posedge clk) disable iff (!primed)
      (load_en && $past(load_en) && $stable(par_in)) |-> $stable(taps));

   // R2
   shift_chk: assert property (@(posedge clk) disable iff (!primed)
      ($past(!load_en) && !jam_seen && !load_en)
         |-> taps[TAP_COUNT-1:1] == $past(taps[TAP_COUNT-2:0]));

endmodule

bind jam_shift_reg jam_shift_reg_chk #(.STAGES(STAGES), .TAP_FIRST(TAP_FIRST)) u_chk (
   .clk    (clk),
   .load_en(load_en),
   .par_in (par_in),
   .ser_in (ser_in),
   .taps   (taps)
);

// File: tb/jam_shift_reg_bench.sv
module jam_shift_reg_bench;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = CLK_PERIOD / 2;
   localparam int NVEC       = 16;

   logic       clk     = 1'b0;
   logic       load_en = 1'b0;
   logic [7:0] par_in  = 8'h00;
   logic       ser_in  = 1'b0;
   logic [2:0] taps;

   logic [7:0] mdl;
   int checks = 0;
   int fails  = 0;

   jam_shift_reg u_jam_shift_reg (
      .clk    (clk),
      .load_en(load_en),
      .par_in (par_in),
      .ser_in (ser_in),
      .taps   (taps)
   );

   // Vector fields: [10] load_en, [9:2] par_in, [1] ser_in, [0] pulse clock
   localparam logic [10:0] VEC [NVEC] = '{
      {1'b1, 8'hA5, 1'b0, 1'b0},
      {1'b1, 8'hA5, 1'b1, 1'b1},
      {1'b0, 8'h00, 1'b1, 1'b1},
      {1'b0, 8'h00, 1'b0, 1'b1},
      {1'b0, 8'h00, 1'b1, 1'b1},
      {1'b0, 8'h00, 1'b1, 1'b0},
      {1'b1, 8'h3C, 1'b0, 1'b0},
      {1'b0, 8'hFF, 1'b0, 1'b1},
      {1'b0, 8'hFF, 1'b1, 1'b1},
      {1'b1, 8'h81, 1'b0, 1'b1},
      {1'b1, 8'h7E, 1'b1, 1'b0},
      {1'b0, 8'h00, 1'b0, 1'b1},
      {1'b0, 8'h00, 1'b1, 1'b1},
      {1'b0, 8'h00, 1'b0, 1'b1},
      {1'b0, 8'h00, 1'b1, 1'b1},
      {1'b0, 8'h00, 1'b1, 1'b1}
   };

   task automatic check(input string tag, input logic [2:0] exp);
      checks++;
      if (taps !== exp) begin
         fails++;
         $display("FAIL %s: taps=%b expected=%b at %0t", tag, taps, exp, $time);
      end
   endtask

   // Full rising+falling clock; model follows the mode level.
   task automatic pulse();
      clk = 1'b1;
      if (!load_en) mdl = {mdl[6:0], ser_in};
      #(HALF);
      clk = 1'b0;
      #(HALF);
   endtask

   task automatic jam(input logic [7:0] v);
      par_in  = v;
      load_en = 1'b1;
      mdl     = v;
      #2;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      mdl = 8'hxx;
      #3;
      // First defined state: capture all ones, then all zeros (R3)
      jam(8'hFF);
      check("R3 capture ones", 3'b111);
      jam(8'h00);
      check("R3 capture zeros", 3'b000);

      // Table walk: R2 shifting, R3/R4 capture, R8 release
      for (int k = 0; k < NVEC; k++) begin
         load_en = VEC[k][10];
         par_in  = VEC[k][9:2];
         ser_in  = VEC[k][1];
         if (load_en) mdl = par_in;
         #2;
         if (VEC[k][0]) pulse();
         check(load_en ? "R3/R4 table capture" : "R2/R8 table shift", mdl[7:5]);
      end

      // R6: tap positions are stages 6,7,8
      jam(8'h20);
      check("R6 stage6 on taps[0]", 3'b001);
      jam(8'h40);
      check("R6 stage7 on taps[1]", 3'b010);
      jam(8'h80);
      check("R6 stage8 on taps[2]", 3'b100);

      // R5: parallel change while capturing reaches stage without clock
      jam(8'h00);
      par_in = 8'hE0; #2;
      check("R5 live change to 111", 3'b111);
      par_in = 8'h40; #2;
      check("R5 live change to 010", 3'b010);
      mdl = 8'h40;

      // R4: clock and serial input ignored while capturing
      jam(8'hA0);
      ser_in = 1'b1;
      pulse(); pulse();
      ser_in = 1'b0;
      pulse();
      check("R4 clocks ignored during capture", 3'b101);

      // R8: release keeps word; par changes ignored; shift resumes on edge
      jam(8'hC0);
      load_en = 1'b0; #2;
      check("R8 released keeps word", 3'b110);
      par_in = 8'h1F; #2;
      check("R8 par ignored after release", 3'b110);
      ser_in = 1'b0;
      pulse();
      check("R8 shift resumes from captured word", mdl[7:5]);

      // R7: falling edge and steady clock hold
      ser_in = 1'b1;
      clk = 1'b1;
      mdl = {mdl[6:0], ser_in};
      #(HALF);
      check("R7 after rising edge", mdl[7:5]);
      ser_in = 1'b0;
      clk = 1'b0;
      #(HALF * 3);
      check("R7 falling edge and idle hold", mdl[7:5]);

      // R1: stage1 bit reaches stage6 after 5 shifts and stage8 after 7
      jam(8'h01);
      load_en = 1'b0; ser_in = 1'b0; #2;
      for (int s = 0; s < 5; s++) pulse();
      check("R1 stage1 bit at stage6", 3'b001);
      pulse(); pulse();
      check("R1 stage1 bit at stage8", 3'b100);

      // R9: eight shifts fully define contents from the serial stream
      jam(8'h5A);
      load_en = 1'b0; #2;
      for (int s = 0; s < 8; s++) begin
         ser_in = (8'b1101_0010 >> (7 - s)) & 1'b1;
         #1;
         pulse();
      end
      // first bit shifted (1) is now in stage8, second (1) in 7, third (0) in 6
      check("R9 serial stream defines contents", 3'b110);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule